// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block serves one vector configuration request at a time. A request carries the application vector length that software asks for and a proposed vector type word. The unit checks the type word, works out how many elements one register group holds for that element width and grouping factor, and grants the smaller of that maximum and the requested length. It then writes the architectural vector length, vector type and start-index registers and reports the granted length on a result port.

A type word that cannot be honoured is never partly accepted. The stored type collapses to a word with only the illegal flag set. The length and start index go to zero, and the reported result is zero. The register width is fixed by the `VLEN` parameter and the widest supported element by `ELEN`. The request port is always ready, so every request that is presented is taken in the cycle it is offered.

Type word layout, with `XLEN` bits and bit 0 the least significant:
- bits [1:0] hold the grouping field `g`, for a group of 2^g registers.
- bits [4:2] hold the width field `w`, for an element width of 8<<w bits.
- bits [6:5] hold the divide field.
- bits [XLEN-2:7] are reserved.
- bit XLEN-1 is the illegal flag.

Top module: `vcfg_unit`

## Requirements
- R1: For a legal type word whose requested length is at least the maximum, the granted length equals (VLEN/8 << g) / (1 << w). Here g is type bits [1:0] and w is type bits [4:2].
- R2: For a legal type word whose requested length is at most the maximum (equality included), the granted length equals the requested length. The granted length never exceeds the requested length.
- R3: For a legal type word, the stored type equals the proposed type word bit for bit.
- R4: A type word whose element width 8<<w exceeds ELEN is illegal.
- R5: A type word with bit XLEN-1 (the illegal flag) set is illegal.
- R6: A type word with a nonzero divide field (bits [6:5]) is illegal.
- R7: A type word with any reserved bit (bits [XLEN-2:7]) set is illegal.
- R8: After an illegal request, the stored type is 1<<(XLEN-1), the stored length is 0 and the reported length is 0. Whenever the stored type has bit XLEN-1 set, the stored length is 0.
- R9: The registers update on the clock edge that accepts a request. `rsp_valid` is high for exactly the one cycle after that edge, and `rsp_vl` then equals the stored length. `req_ready` is always 1.
- R10: After any accepted request, legal or illegal, the start index is 0.
- R11: After reset, the stored type is 1<<(XLEN-1), the length and start index are 0, and `rsp_valid` is 0.
- R12: In a cycle with no request, the stored length and type hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_avl | input | XLEN | Requested application vector length |
| req_vtype | input | XLEN | Proposed vector type word |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| rsp_vl | output | XLEN | Granted vector length |
| vl_q | output | XLEN | Architectural vector length register |
| vtype_q | output | XLEN | Architectural vector type register |
| vstart_q | output | XLEN | Architectural start-index register |

## Verification
Every result is due exactly one clock edge after acceptance. The registers, `rsp_valid` and `rsp_vl` all change on the edge that takes the request. The bench presents a request on a falling edge and withdraws it at the next falling edge. It samples all outputs at that falling edge, which is half a period after the updating edge. It checks one more falling edge later that `rsp_valid` has dropped and the registers have held their values.

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_avl,
  input  logic [XLEN-1:0] req_vtype,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_vl,
  output logic [XLEN-1:0] vl_q,
  output logic [XLEN-1:0] vtype_q,
  output logic [XLEN-1:0] vstart_q
);
  localparam int REG_BYTES = VLEN / 8;
  localparam int EW_MAX    = $clog2(ELEN / 8);
  localparam int RSV_LO    = 7;
  localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  logic [1:0]      grp;
  logic [2:0]      ew;
  logic [1:0]      div;
  logic            bad;
  logic [XLEN-1:0] vlmax;
  logic [XLEN-1:0] grant;

  assign req_ready = 1'b1;
  assign grp = req_vtype[1:0];
  assign ew  = req_vtype[4:2];
  assign div = req_vtype[6:5];

  assign bad = (ew > 3'(EW_MAX)) || req_vtype[XLEN-1] || (div != 2'b00)
            || (req_vtype[XLEN-2:RSV_LO] != '0);

  assign vlmax = (XLEN'(REG_BYTES) << grp) >> ew;
  assign grant = bad ? '0 : ((req_avl <= vlmax) ? req_avl : vlmax);

  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_q   <= ILL_WORD;
      vl_q      <= '0;
      vstart_q  <= '0;
      rsp_vl    <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        vtype_q  <= bad ? ILL_WORD : req_vtype;
        vl_q     <= grant;
        vstart_q <= '0;
        rsp_vl   <= grant;
      end
    end
  end
endmodule

module vcfg_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [XLEN-1:0] req_avl,
  input logic [XLEN-1:0] req_vtype,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_vl,
  input logic [XLEN-1:0] vl_q,
  input logic [XLEN-1:0] vtype_q,
  input logic [XLEN-1:0] vstart_q
);
  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R9
  rsp_match_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_vl == vl_q));
  // R2
  vl_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_vl <= $past(req_avl)));
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> (vl_q == '0));
  // R5
  flag_in_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_vtype[XLEN-1]) |=> (vtype_q == {1'b1, {(XLEN-1){1'b0}}}));
  // R6
  div_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_vtype[6:5] != 2'b00) |=> vtype_q[XLEN-1]);
  // R10
  vstart_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (vstart_q == '0));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(vl_q) && $stable(vtype_q)));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/vcfg_unit_tb.sv
module vcfg_unit_tb;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam logic [31:0] ILLW = 32'h8000_0000;

  logic clk = 0, rst = 1, req_valid = 0;
  logic req_ready, rsp_valid;
  logic [31:0] req_avl = 0, req_vtype = 0, rsp_vl, vl_q, vtype_q, vstart_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] avl, logic [31:0] vt, string req);
    logic bad;
    int ewb, vmax;
    logic [31:0] evl, evt;
    ewb  = 8 << vt[4:2];
    vmax = (VLEN / 8 << vt[1:0]) / (ewb / 8);
    bad  = (ewb > ELEN) || vt[31] || (vt[6:5] != 0) || (vt[30:7] != 0);
    evl  = bad ? 0 : ((avl <= vmax) ? avl : vmax);
    evt  = bad ? ILLW : vt;
    @(negedge clk);
    req_valid = 1; req_avl = avl; req_vtype = vt;
    @(negedge clk);
    req_valid = 0; req_avl = 32'hFFFF_FFFF; req_vtype = 32'h0000_0001;
    chk({req, " R9 rsp_valid"}, rsp_valid, 1);
    chk({req, " vl"}, vl_q, evl);
    chk({req, " R9 rsp_vl"}, rsp_vl, evl);
    chk({req, " vtype"}, vtype_q, evt);
    chk({req, " R10 vstart"}, vstart_q, 0);
    @(negedge clk);
    chk({req, " R9 pulse"}, rsp_valid, 0);
    chk({req, " R12 hold vl"}, vl_q, evl);
    chk({req, " R12 hold vtype"}, vtype_q, evt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 vtype", vtype_q, ILLW);
    chk("R11 vl", vl_q, 0);
    chk("R11 vstart", vstart_q, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R9 ready", req_ready, 1);
    for (int w = 0; w < 8; w++) begin
      for (int g = 0; g < 4; g++) begin
        logic [31:0] vt;
        int vmax;
        vt = {25'd0, 3'(w), 2'(g)};
        vmax = (VLEN / 8 << g) >> w;
        if (w > 3) issue(32'd5, vt, "R4 wide element");
        else begin
          issue(32'hFFFF_FFFF, vt, "R1 R3 max");
          issue(vmax + 1, vt, "R1 above");
          issue(vmax, vt, "R2 equal");
          issue(vmax - 1, vt, "R2 below");
          issue(0, vt, "R2 zero");
        end
      end
    end
    issue(32'd7, 32'h0000_0006, "R3 legal again");
    issue(32'd7, ILLW | 32'h6, "R5 flag");
    for (int d = 1; d < 4; d++) issue(32'd3, {25'd0, 2'(d), 5'd4}, "R6 div");
    for (int b = 7; b < 31; b++) issue(32'd3, (32'd1 << b) | 32'h1, "R7 reserved");
    issue(32'd9, 32'h0000_0000, "R3 recover");
    issue(32'd9, 32'h0000_0020, "R8 illegal");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule